// File: doc/BRIEF.md
# Privileged Control Register File

This block holds the privileged control state of a processor core: translation staging registers, the interrupt enable and mask word, the interrupt cause word, configuration, watch, debug and error-return registers. Software reaches it with move-to and move-from operations. Each operation carries a 5-bit register number and a 3-bit select. Writes are synchronous and land on the next rising clock edge. Reads are combinational from the register number and select that are presented.

Each register applies its own mask on write. Some fields keep their current value whatever is written, and others can be set only by hardware. The free-running timer, the random replacement value and the load-linked address come in on input ports and are read-only here. The block keeps four mode flags: user mode, exception level, error level and debug mode. It also holds an interrupt request level, which a write to the status register can raise or withdraw. Six hardware interrupt lines are shown live in cause bits 15:10.

Top module: `sysctl_regs`

## Requirements
- R1: An access with a nonzero select to any register number other than 16 or 28 is invalid. `wr_bad` or `rd_bad` is 1 for it. An invalid read returns 0. An invalid write changes no register, no mode flag and not the interrupt request.
- R2: A write to register 0 (index) keeps the current bit 31 and takes bits 3:0 from the data. Bits 30:4 read as 0.
- R3: Registers 2 and 3 store data bits 29:0. Register 4 keeps its bits 31:24 and takes bits 23:4 from the data.
- R4: Register 5 stores data & 0x01FFE000. Register 6 stores data & 0x0000000F. Register 10 stores data & 0xFFFFF0FF. Register 19 stores data & 0x40FF0FF8. Register 28 select 0 stores data & 0xFFFFFCF6. Register 16 select 0 keeps the bits in 0xFE17FF80 and takes bit 0 from the data.
- R5: Register 12 (status) stores data & 0xFA78FF01. A status write loads the user flag from data bit 4, the error-level flag from bit 2 and the exception-level flag from bit 1. A status read ORs the flags back into bits 4, 2 and 1.
- R6: A status write raises `irq_req` on the next edge when all of these hold: data bit 0 is 1, the stored bit 0 was 0, data bits 1 and 2 are 0, debug mode is clear, and (data & cause) has a 1 in bits 15:8.
- R7: A status write with data bit 0 = 0, while stored bit 0 is 1, clears `irq_req`. A status write that meets neither the R6 condition nor this one leaves `irq_req` unchanged.
- R8: A write to register 13 (cause) keeps the bits in 0xB000F87C and takes bits 9:8 from the data. A cause read ORs `irq_lines` into bits 15:10.
- R9: A read of register 17 returns `ll_addr_in` shifted right by 4.
- R10: A write to register 23 (debug) keeps the bits in 0x8C03FC1F and takes the bits in 0x13300120 from the data. Data bit 30 loads the debug-mode flag, and reads show that flag in bit 30.
- R11: Register numbers 7, 8, 14, 15, 20, 21, 22, 24, 25, 26, 27 and 29 are unimplemented. So are register 16 with select 2 to 7 and register 28 with select 1 to 7. These read 0 and ignore writes, with no invalid flag.
- R12: Register 1 reads `random_in` and register 9 reads `count_in`; writes to registers 1, 9 and 17 are ignored. Registers 11, 18, 30 and 31 store all 32 data bits. Register 16 select 1 reads the constant CFG1_VALUE. After reset every stored register is 0, except register 16 select 0, which holds CFG0_INIT, and all flags and `irq_req` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Move-to strobe |
| wr_num | input | 5 | Register number for the write |
| wr_sel | input | 3 | Select for the write |
| wr_data | input | 32 | Write data |
| wr_bad | output | 1 | Write address is an invalid access |
| rd_num | input | 5 | Register number for the read |
| rd_sel | input | 3 | Select for the read |
| rd_data | output | 32 | Read data |
| rd_bad | output | 1 | Read address is an invalid access |
| count_in | input | 32 | External timer value |
| random_in | input | 32 | External random replacement value |
| ll_addr_in | input | 32 | Load-linked address |
| irq_lines | input | 6 | Hardware interrupt lines, shown in cause bits 15:10 |
| mode_user | output | 1 | User-mode flag |
| mode_exl | output | 1 | Exception-level flag |
| mode_erl | output | 1 | Error-level flag |
| mode_debug | output | 1 | Debug-mode flag |
| irq_req | output | 1 | Hardware interrupt request level |

## Verification
Two things can change in the same cycle: a hardware interrupt line can rise while a status write sets the enable bit. The bench provokes this by driving the line and the status write in the same cycle. It then requires `irq_req` to be 1 after that edge, because the pending test uses the lines as they are in the write cycle. A second overlap is a status write whose exception-level or error-level bit is set while an interrupt is pending. There the mode bits of the same write must block the raise, and the bench expects `irq_req` to stay 0.

// File: rtl/sysctl_regs.sv
module sysctl_regs #(
  parameter logic [31:0] CFG0_INIT  = 32'h8000_8480,
  parameter logic [31:0] CFG1_VALUE = 32'h1E01_0C90
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [4:0]  wr_num,
  input  logic [2:0]  wr_sel,
  input  logic [31:0] wr_data,
  output logic        wr_bad,
  input  logic [4:0]  rd_num,
  input  logic [2:0]  rd_sel,
  output logic [31:0] rd_data,
  output logic        rd_bad,
  input  logic [31:0] count_in,
  input  logic [31:0] random_in,
  input  logic [31:0] ll_addr_in,
  input  logic [5:0]  irq_lines,
  output logic        mode_user,
  output logic        mode_exl,
  output logic        mode_erl,
  output logic        mode_debug,
  output logic        irq_req
);
  localparam logic [31:0] STAT_WMASK  = 32'hFA78_FF01;
  localparam logic [31:0] CAUSE_KEEP  = 32'hB000_F87C;
  localparam logic [31:0] CAUSE_WMASK = 32'h0000_0300;
  localparam logic [31:0] CFG0_KEEP   = 32'hFE17_FF80;
  localparam logic [31:0] DBG_KEEP    = 32'h8C03_FC1F;
  localparam logic [31:0] DBG_WMASK   = 32'h1330_0120;

  logic [31:0] idx_q, elo0_q, elo1_q, ctx_q, pmask_q, wired_q, ehi_q, cmp_q;
  logic [31:0] stat_q, cause_q, cfg0_q, wlo_q, whi_q, dbg_q, tag_q, eepc_q, save_q;
  logic        um_q, exl_q, erl_q, dm_q, irq_q;

  assign wr_bad = (wr_sel != 3'd0) && (wr_num != 5'd16) && (wr_num != 5'd28);
  assign rd_bad = (rd_sel != 3'd0) && (rd_num != 5'd16) && (rd_num != 5'd28);

  wire        we       = wr_en && !wr_bad;
  wire        w_sel0   = we && (wr_sel == 3'd0);
  wire        w_stat   = w_sel0 && (wr_num == 5'd12);
  wire [31:0] cause_rd = cause_q | {16'd0, irq_lines, 10'd0};
  wire [31:0] stat_new = wr_data & STAT_WMASK;
  wire        pending  = |(stat_new[15:8] & cause_rd[15:8]);
  wire        raise    = w_stat && wr_data[0] && !stat_q[0] && !wr_data[1] &&
                         !wr_data[2] && !dm_q && pending;
  wire        withdraw = w_stat && !wr_data[0] && stat_q[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q <= '0; elo0_q <= '0; elo1_q <= '0; ctx_q <= '0;
      pmask_q <= '0; wired_q <= '0; ehi_q <= '0; cmp_q <= '0;
      stat_q <= '0; cause_q <= '0; cfg0_q <= CFG0_INIT; wlo_q <= '0;
      whi_q <= '0; dbg_q <= '0; tag_q <= '0; eepc_q <= '0; save_q <= '0;
      um_q <= 1'b0; exl_q <= 1'b0; erl_q <= 1'b0; dm_q <= 1'b0;
      irq_q <= 1'b0;
    end else begin
      if (raise) irq_q <= 1'b1;
      else if (withdraw) irq_q <= 1'b0;
      if (w_sel0) begin
        case (wr_num)
          5'd0:  idx_q   <= (idx_q & 32'h8000_0000) | (wr_data & 32'h0000_000F);
          5'd2:  elo0_q  <= wr_data & 32'h3FFF_FFFF;
          5'd3:  elo1_q  <= wr_data & 32'h3FFF_FFFF;
          5'd4:  ctx_q   <= (ctx_q & 32'hFF00_0000) | (wr_data & 32'h00FF_FFF0);
          5'd5:  pmask_q <= wr_data & 32'h01FF_E000;
          5'd6:  wired_q <= wr_data & 32'h0000_000F;
          5'd10: ehi_q   <= wr_data & 32'hFFFF_F0FF;
          5'd11: cmp_q   <= wr_data;
          5'd12: begin
            stat_q <= stat_new;
            um_q   <= wr_data[4];
            erl_q  <= wr_data[2];
            exl_q  <= wr_data[1];
          end
          5'd13: cause_q <= (cause_q & CAUSE_KEEP) | (wr_data & CAUSE_WMASK);
          5'd16: cfg0_q  <= (cfg0_q & CFG0_KEEP) | (wr_data & 32'h0000_0001);
          5'd18: wlo_q   <= wr_data;
          5'd19: whi_q   <= wr_data & 32'h40FF_0FF8;
          5'd23: begin
            dbg_q <= (dbg_q & DBG_KEEP) | (wr_data & DBG_WMASK);
            dm_q  <= wr_data[30];
          end
          5'd28: tag_q   <= wr_data & 32'hFFFF_FCF6;
          5'd30: eepc_q  <= wr_data;
          5'd31: save_q  <= wr_data;
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    rd_data = '0;
    if (!rd_bad) begin
      case (rd_num)
        5'd0:  rd_data = idx_q;
        5'd1:  rd_data = random_in;
        5'd2:  rd_data = elo0_q;
        5'd3:  rd_data = elo1_q;
        5'd4:  rd_data = ctx_q;
        5'd5:  rd_data = pmask_q;
        5'd6:  rd_data = wired_q;
        5'd9:  rd_data = count_in;
        5'd10: rd_data = ehi_q;
        5'd11: rd_data = cmp_q;
        5'd12: rd_data = stat_q | {27'd0, um_q, 1'b0, erl_q, exl_q, 1'b0};
        5'd13: rd_data = cause_rd;
        5'd16: rd_data = (rd_sel == 3'd0) ? cfg0_q :
                         (rd_sel == 3'd1) ? CFG1_VALUE : 32'd0;
        5'd17: rd_data = ll_addr_in >> 4;
        5'd18: rd_data = wlo_q;
        5'd19: rd_data = whi_q;
        5'd23: rd_data = dbg_q | {1'b0, dm_q, 30'd0};
        5'd28: rd_data = (rd_sel == 3'd0) ? tag_q : 32'd0;
        5'd30: rd_data = eepc_q;
        5'd31: rd_data = save_q;
        default: rd_data = '0;
      endcase
    end
  end

  assign mode_user  = um_q;
  assign mode_exl   = exl_q;
  assign mode_erl   = erl_q;
  assign mode_debug = dm_q;
  assign irq_req    = irq_q;
endmodule

// File: rtl/sysctl_regs_chk.sv
module sysctl_regs_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        wr_en,
  input logic [4:0]  wr_num,
  input logic [2:0]  wr_sel,
  input logic [31:0] wr_data,
  input logic        wr_bad,
  input logic [4:0]  rd_num,
  input logic [2:0]  rd_sel,
  input logic [31:0] rd_data,
  input logic        rd_bad,
  input logic        mode_user,
  input logic        mode_exl,
  input logic        mode_erl,
  input logic        mode_debug,
  input logic        irq_req
);
  AST_BAD_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    rd_bad |-> rd_data == 32'd0); // R1
  AST_BAD_WRITE_INERT: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_bad) |=> ($stable(mode_user) && $stable(mode_exl) && $stable(mode_erl) && $stable(mode_debug) && $stable(irq_req))); // R1
  AST_MODE_FROM_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
    !($stable(mode_user) && $stable(mode_exl) && $stable(mode_erl)) |-> $past(wr_en && wr_num == 5'd12 && wr_sel == 3'd0)); // R5
  AST_IRQ_RISE_SRC: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_req) |-> $past(wr_en && wr_num == 5'd12 && wr_sel == 3'd0 && wr_data[0])); // R6
  AST_IRQ_RISE_MODES: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_req) |-> ($past(!wr_data[1] && !wr_data[2]) && !$past(mode_debug))); // R6
  AST_IRQ_FALL_SRC: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irq_req) |-> $past(wr_en && wr_num == 5'd12 && wr_sel == 3'd0 && !wr_data[0])); // R7
  AST_LL_TOP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_num == 5'd17 && rd_sel == 3'd0) |-> rd_data[31:28] == 4'd0); // R9
  AST_DEBUG_FROM_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(mode_debug) |-> $past(wr_en && wr_num == 5'd23 && wr_sel == 3'd0)); // R10
endmodule

bind sysctl_regs sysctl_regs_chk u_chk (.*);

// File: tb/test_sysctl_regs.sv
module test_sysctl_regs;
  localparam logic [31:0] CFG0 = 32'h8000_8480;
  localparam logic [31:0] CFG1 = 32'h1E01_0C90;

  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [4:0] wr_num = '0, rd_num = '0;
  logic [2:0] wr_sel = '0, rd_sel = '0;
  logic [31:0] wr_data = '0, count_in = '0, random_in = '0, ll_addr_in = '0;
  logic [5:0] irq_lines = '0;
  logic wr_bad, rd_bad, mode_user, mode_exl, mode_erl, mode_debug, irq_req;
  logic [31:0] rd_data;

  int checks = 0, errors = 0;
  logic [31:0] exp_r [32];
  logic last_bad;
  bit done = 1'b0;

  always #5 clk = ~clk;

  sysctl_regs #(.CFG0_INIT(CFG0), .CFG1_VALUE(CFG1)) i_sysctl_regs (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (act !== expv) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, expv);
    end
  endtask

  task automatic do_wr(input logic [4:0] n, input logic [2:0] s, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_num = n; wr_sel = s; wr_data = d;
    #1 last_bad = wr_bad;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [4:0] n, input logic [2:0] s, output logic [31:0] v);
    rd_num = n; rd_sel = s;
    #1 v = rd_data;
  endtask

  function automatic logic [31:0] model(input int n, input logic [31:0] o, input logic [31:0] d);
    case (n)
      0:  return (o & 32'h8000_0000) | (d & 32'hF);
      2, 3: return d & 32'h3FFF_FFFF;
      4:  return (o & 32'hFF00_0000) | (d & 32'h00FF_FFF0);
      5:  return d & 32'h01FF_E000;
      6:  return d & 32'hF;
      10: return d & 32'hFFFF_F0FF;
      11, 18, 30, 31: return d;
      12: return (d & 32'hFA78_FF01) | (d & 32'h16);
      13: return (o & 32'hB000_F87C) | (d & 32'h300);
      16: return (o & 32'hFE17_FF80) | (d & 32'h1);
      19: return d & 32'h40FF_0FF8;
      23: return (o & 32'h8C03_FC1F) | (d & 32'h1330_0120) | (d & 32'h4000_0000);
      28: return d & 32'hFFFF_FCF6;
      default: return o;
    endcase
  endfunction

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin : main
    logic [31:0] v;
    logic [31:0] pats [5];
    pats[0] = 32'hFFFF_FFFF; pats[1] = 32'h0000_0000; pats[2] = 32'hA5A5_A5A5;
    pats[3] = 32'h5A5A_5A5A; pats[4] = 32'h1234_5678;
    for (int i = 0; i < 32; i++) exp_r[i] = 32'd0;
    exp_r[16] = CFG0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R12 reset state
    for (int n = 0; n < 32; n++) begin
      rd(5'(n), 3'd0, v);
      chk($sformatf("R12 reset reg %0d", n), v, exp_r[n]);
    end
    chk("R12 reset flags", {27'd0, mode_user, mode_exl, mode_erl, mode_debug, irq_req}, 32'd0);

    // R2 R3 R4 R5 R8 R10 R11 R12 masked write sweep
    for (int p = 0; p < 5; p++) begin
      for (int n = 0; n < 32; n++) begin
        do_wr(5'(n), 3'd0, pats[p]);
        exp_r[n] = model(n, exp_r[n], pats[p]);
        chk($sformatf("R1 valid addr reg %0d", n), {31'd0, last_bad}, 32'd0);
        rd(5'(n), 3'd0, v);
        chk($sformatf("R2-R12 write reg %0d pat %h", n, pats[p]), v, exp_r[n]);
        if (n == 12)
          chk("R5 mode flags", {29'd0, mode_user, mode_erl, mode_exl},
              {29'd0, pats[p][4], pats[p][2], pats[p][1]});
        if (n == 23)
          chk("R10 debug flag", {31'd0, mode_debug}, {31'd0, pats[p][30]});
      end
    end
    do_wr(5'd12, 3'd0, 32'd0); exp_r[12] = 32'd0;
    do_wr(5'd13, 3'd0, 32'd0); exp_r[13] = 32'd0;
    do_wr(5'd23, 3'd0, 32'd0); exp_r[23] = 32'd0;
    chk("R7 irq clear after cleanup", {31'd0, irq_req}, 32'd0);

    // R1 R11 select sweep
    for (int n = 0; n < 32; n++) begin
      for (int s = 1; s < 8; s++) begin
        logic bad;
        bad = (n != 16) && (n != 28);
        do_wr(5'(n), 3'(s), 32'hFFFF_FFFF);
        chk($sformatf("R1 wr_bad reg %0d sel %0d", n, s), {31'd0, last_bad}, {31'd0, bad});
        rd(5'(n), 3'(s), v);
        chk($sformatf("R1 rd_bad reg %0d sel %0d", n, s), {31'd0, rd_bad}, {31'd0, bad});
        chk($sformatf("R11 read reg %0d sel %0d", n, s), v, (n == 16 && s == 1) ? CFG1 : 32'd0);
      end
    end
    for (int n = 0; n < 32; n++) begin
      rd(5'(n), 3'd0, v);
      chk($sformatf("R1 unchanged reg %0d", n), v, exp_r[n]);
    end
    chk("R1 flags unchanged", {27'd0, mode_user, mode_exl, mode_erl, mode_debug, irq_req}, 32'd0);

    // R9 R12 external inputs
    count_in = 32'hDEAD_BEEF; random_in = 32'h0000_0007; ll_addr_in = 32'h1234_5678;
    rd(5'd9, 3'd0, v);  chk("R12 count read", v, 32'hDEAD_BEEF);
    rd(5'd1, 3'd0, v);  chk("R12 random read", v, 32'h7);
    rd(5'd17, 3'd0, v); chk("R9 ll shift", v, 32'h0123_4567);
    ll_addr_in = 32'hFFFF_FFFF;
    rd(5'd17, 3'd0, v); chk("R9 ll shift ones", v, 32'h0FFF_FFFF);

    // R8 cause shows lines
    irq_lines = 6'b101001;
    rd(5'd13, 3'd0, v); chk("R8 lines in cause", v, 32'h0000_A400);

    // R6 raise with hardware line
    irq_lines = 6'b000001;
    do_wr(5'd12, 3'd0, 32'h0000_0401);
    chk("R6 raise hw", {31'd0, irq_req}, 32'd1);
    do_wr(5'd12, 3'd0, 32'h0000_0000);
    chk("R7 withdraw", {31'd0, irq_req}, 32'd0);
    // R6 no pending
    irq_lines = 6'b000000;
    do_wr(5'd12, 3'd0, 32'h0000_0401);
    chk("R6 no pending", {31'd0, irq_req}, 32'd0);
    // R6 IE already set
    irq_lines = 6'b000001;
    do_wr(5'd12, 3'd0, 32'h0000_0401);
    chk("R6 IE already set", {31'd0, irq_req}, 32'd0);
    // R6 EXL / ERL block
    do_wr(5'd12, 3'd0, 32'h0);
    do_wr(5'd12, 3'd0, 32'h0000_0403);
    chk("R6 exl blocks", {31'd0, irq_req}, 32'd0);
    do_wr(5'd12, 3'd0, 32'h0);
    do_wr(5'd12, 3'd0, 32'h0000_0405);
    chk("R6 erl blocks", {31'd0, irq_req}, 32'd0);
    // R6 debug mode blocks
    do_wr(5'd12, 3'd0, 32'h0);
    do_wr(5'd23, 3'd0, 32'h4000_0000);
    do_wr(5'd12, 3'd0, 32'h0000_0401);
    chk("R6 debug blocks", {31'd0, irq_req}, 32'd0);
    do_wr(5'd23, 3'd0, 32'h0);
    do_wr(5'd12, 3'd0, 32'h0);
    // R6 mask mismatch
    do_wr(5'd12, 3'd0, 32'h0000_0801);
    chk("R6 mask mismatch", {31'd0, irq_req}, 32'd0);
    do_wr(5'd12, 3'd0, 32'h0);
    // R6 R8 software bit
    irq_lines = 6'b000000;
    do_wr(5'd13, 3'd0, 32'h0000_0100);
    do_wr(5'd12, 3'd0, 32'h0000_0101);
    chk("R6 raise sw", {31'd0, irq_req}, 32'd1);
    // R7 rewrite with bit0 set holds
    do_wr(5'd12, 3'd0, 32'h0000_0101);
    chk("R7 hold", {31'd0, irq_req}, 32'd1);
    do_wr(5'd12, 3'd0, 32'h0000_0100);
    chk("R7 withdraw sw", {31'd0, irq_req}, 32'd0);
    do_wr(5'd12, 3'd0, 32'h0000_0000);
    chk("R7 stays clear", {31'd0, irq_req}, 32'd0);
    do_wr(5'd13, 3'd0, 32'h0);
    // R6 line rises in the same cycle as the enabling write
    @(negedge clk);
    wr_en = 1'b1; wr_num = 5'd12; wr_sel = 3'd0; wr_data = 32'h0000_0401;
    irq_lines = 6'b000001;
    @(negedge clk);
    wr_en = 1'b0;
    chk("R6 same-cycle line", {31'd0, irq_req}, 32'd1);
    // R1 invalid status write does not withdraw
    do_wr(5'd12, 3'd3, 32'h0);
    chk("R1 bad write no withdraw", {31'd0, irq_req}, 32'd1);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule